// File: doc/BRIEF.md
# Scrolling Pattern Row Buffer

This block animates an image that scrolls vertically on a monochrome display of eight rows of eight pixels. A tick divider, turned on by a start input, makes a periodic step enable. On each step a line counter selects one row of a small constant pattern table. That row goes into the top stage of a stack of row registers, and every other stage takes the row held directly above it. The stack is driven out in parallel as one frame word for a display driver.

The table feeds the first register stage and never drives the top displayed row directly. All displayed rows therefore move on the same step. The line counter runs from zero up to a programmable last line and then starts again at zero. This lets a shorter part of the table repeat.

Top module: `rowscroll_top`

## Requirements
- R1: While `rst` is high at a rising edge, every row register clears, the line counter goes to 0 and the divider count goes to 0. After reset, `frame` reads 0.
- R2: While `start` is low, no step happens and `frame` holds its value.
- R3: While `start` is high, one step happens every `divLen`+1 cycles. The divider counts cycles from 0 and steps when its count is at or above `divLen`, then returns to 0.
- R4: On a step, row k (k = 1..7) takes the value row k-1 held before the step. As a result, the lower 56 bits of `frame` take the old upper 56 bits.
- R5: On a step, row 0 takes the table byte at the current line address. The table byte reaches `frame` only through this register.
- R6: On a step, the line counter goes to 0 if it is at or above `lastLine`, and otherwise adds 1. `lastLine` is compared again at every step.
- R7: The default table holds, at addresses 0 to 7, the bytes 0x18, 0x24, 0x42, 0x81, 0x81, 0x42, 0x24, 0x18.
- R8: `frame` places row 0 (the top row) in bits [63:56] down to row 7 in bits [7:0], with bit 7 of each byte as the leftmost pixel. Eight steps after reset with `lastLine`=7, `frame` is 0x1824428181422418.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Enables the tick divider |
| divLen | input | 8 | Step period minus one, in cycles |
| lastLine | input | 3 | Highest line address before the wrap |
| frame | output | 64 | All rows, row 0 in the top byte |

## Verification
The first directed run uses `divLen`=0 and `lastLine`=7. It steps every cycle, which shows the table contents and the row order in the frame. A second run with `lastLine`=2 produces a frame with a three-row period, which can only come from a correct wrap. Stimulus with start held low tells a held frame apart from a frame that advances anyway. A long random run varies `divLen`, `lastLine` and `start`, and follows a bench model cycle by cycle. It separates a wrong divider period, an off-by-one wrap and a broken shift order.

// File: rtl/rowscroll_pkg.sv
package rowscroll_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic       shiftEn;
    logic [2:0] lineAddr;
  } ctrlStrobe_t;
endpackage

// File: rtl/rowscroll_ctrl.sv
module rowscroll_ctrl #(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  divLen,
  input  logic [ADDR_W-1:0] lastLine,
  output rowscroll_pkg::ctrlStrobe_t strobe
);
  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] lineAddr;
  logic              tick;

  assign tick = start && (divCnt >= divLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (start) begin
      if (tick) divCnt <= '0;
      else      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineAddr <= '0;
    end else if (tick) begin
      if (lineAddr >= lastLine) lineAddr <= '0;
      else                      lineAddr <= lineAddr + 1'b1;
    end
  end

  assign strobe.shiftEn  = tick;
  assign strobe.lineAddr = lineAddr;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !start |-> !strobe.shiftEn);
  p_divstep_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !tick) |=> (divCnt == $past(divCnt) + 1'b1));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && lineAddr >= lastLine) |=> (lineAddr == '0));
  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && lineAddr < lastLine) |=> (lineAddr == $past(lineAddr) + 1'b1));
endmodule

// File: rtl/rowscroll_dp.sv
module rowscroll_dp #(
  parameter int ROW_W  = 8,
  parameter int ROWS   = 8,
  parameter int ADDR_W = 3,
  parameter logic [ROWS*ROW_W-1:0] PATTERN = 64'h1824_4281_8142_2418
) (
  input  logic                     clk,
  input  logic                     rst,
  input  rowscroll_pkg::ctrlStrobe_t strobe,
  output logic [ROWS*ROW_W-1:0]    frame
);
  logic [ROW_W-1:0] rows [ROWS];
  logic [ROW_W-1:0] romByte;

  // address 0 sits in the most significant byte of PATTERN
  always_comb begin
    romByte = '0;
    for (int a = 0; a < ROWS; a++)
      if (strobe.lineAddr == ADDR_W'(a))
        romByte = PATTERN[(ROWS-1-a)*ROW_W +: ROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst)                 rows[0] <= '0;
    else if (strobe.shiftEn) rows[0] <= romByte;
  end

  for (genvar k = 1; k < ROWS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)                 rows[k] <= '0;
      else if (strobe.shiftEn) rows[k] <= rows[k-1];
    end
  end

  for (genvar k = 0; k < ROWS; k++) begin : g_pack
    assign frame[(ROWS-1-k)*ROW_W +: ROW_W] = rows[k];
  end

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftEn |=> (rows[0] == $past(romByte)));
  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftEn |=> (frame[(ROWS-1)*ROW_W-1:0] == $past(frame[ROWS*ROW_W-1:ROW_W])));
  p_still_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(frame));
endmodule

// File: rtl/rowscroll_top.sv
module rowscroll_top #(
  parameter int ROW_W  = 8,
  parameter int ROWS   = 8,
  parameter int DIV_W  = 8,
  parameter logic [ROWS*ROW_W-1:0] PATTERN = 64'h1824_4281_8142_2418,
  localparam int ADDR_W  = $clog2(ROWS),
  localparam int FRAME_W = ROWS * ROW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DIV_W-1:0]   divLen,
  input  logic [ADDR_W-1:0]  lastLine,
  output logic [FRAME_W-1:0] frame
);
  rowscroll_pkg::ctrlStrobe_t strobe;

  rowscroll_ctrl #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .divLen(divLen),
    .lastLine(lastLine), .strobe(strobe)
  );

  rowscroll_dp #(.ROW_W(ROW_W), .ROWS(ROWS), .ADDR_W(ADDR_W), .PATTERN(PATTERN)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .frame(frame)
  );

  p_resetclear_r1: assert property (@(posedge clk) rst |=> (frame == '0));
endmodule

// File: tb/rowscroll_top_tb.sv
module rowscroll_top_tb;
  localparam logic [63:0] PAT = 64'h1824_4281_8142_2418;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  divLen = 8'd0;
  logic [2:0]  lastLine = 3'd7;
  logic [63:0] frame;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state
  logic [7:0]  mDiv;
  logic [2:0]  mLine;
  logic [63:0] mFrame;

  always #5 clk = ~clk;

  rowscroll_top u_dut (
    .clk(clk), .rst(rst), .start(start), .divLen(divLen),
    .lastLine(lastLine), .frame(frame)
  );

  function automatic logic [7:0] tableByte(input logic [2:0] a);
    return PAT[63 - 8*a -: 8];
  endfunction

  function automatic logic [2:0] nextLine(input logic [2:0] cur, input logic [2:0] last);
    return (cur >= last) ? 3'd0 : cur + 3'd1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mDiv <= 8'd0; mLine <= 3'd0; mFrame <= 64'd0;
    end else if (start) begin
      if (mDiv >= divLen) begin
        mDiv   <= 8'd0;
        mFrame <= {tableByte(mLine), mFrame[63:8]};
        mLine  <= nextLine(mLine, lastLine);
      end else begin
        mDiv <= mDiv + 8'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; start = 1'b0;
    cyc(2);
    rst = 1'b0;
  endtask

  initial begin
    cyc(20_0000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    doReset();
    chk("R1 reset frame", frame, 64'd0);

    // R2: start low, inputs wander, frame stays cleared
    for (int i = 0; i < 10; i++) begin
      divLen = 8'($urandom_range(0, 3)); lastLine = 3'($urandom);
      cyc(1);
    end
    chk("R2 hold while stopped", frame, 64'd0);

    // R5/R7/R8: step every cycle, full pattern
    divLen = 8'd0; lastLine = 3'd7; start = 1'b1;
    cyc(1);
    chk("R5 top row after one step", frame, 64'h1800_0000_0000_0000);
    cyc(7);
    chk("R8 full frame after eight steps", frame, 64'h1824_4281_8142_2418);
    start = 1'b0;
    cyc(5);
    chk("R2 hold after stop", frame, 64'h1824_4281_8142_2418);

    // R6: lastLine=2 gives a three-row period
    doReset();
    divLen = 8'd0; lastLine = 3'd2; start = 1'b1;
    cyc(6);
    chk("R6 wrap at lastLine", frame, 64'h4224_1842_2418_0000);
    start = 1'b0;

    // R3: divLen=3, step every 4 cycles
    doReset();
    divLen = 8'd3; lastLine = 3'd7; start = 1'b1;
    cyc(3);
    chk("R3 no step before period", frame, 64'd0);
    cyc(1);
    chk("R3 step at period", frame, 64'h1800_0000_0000_0000);
    cyc(4);
    chk("R3 second step", frame, 64'h2418_0000_0000_0000);

    // R1: reset mid-run clears
    doReset();
    chk("R1 reset mid-run", frame, 64'd0);

    // random run against the model (R3 R4 R5 R6)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) divLen = 8'($urandom_range(0, 5));
      if ($urandom_range(0, 29) == 0) lastLine = 3'($urandom);
      start = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 999) == 0) rst = 1'b1; else rst = 1'b0;
      cyc(1);
      chk("R4 R6 random vs model", frame, mFrame);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule